// File: doc/BRIEF.md
# Interrupt Vector and DMA Request Unit

This block sits between a serial-bus controller's status word and the rest of the chip. It keeps a small interrupt enable mask and a two-bit DMA configuration, and from these and the incoming status flags it produces one interrupt line and two DMA request lines, one for receive and one for transmit. The block does not generate status itself. When software reads the vector register, the block returns a clear pulse to the status owner.

Software reads a vector register to learn which enabled event is pending. The read returns the 1-based number of the lowest-numbered pending enabled flag and clears that flag alone. The clear goes out as a one-hot pulse in the same cycle as the read strobe. Switching on DMA for a direction also switches off that direction's ready interrupt enable, so the CPU and the DMA engine never both service the same ready flag.

The register port uses a 2-bit select. Select 0 is the enable mask, 1 is the DMA configuration, 2 is the status (read-only) and 3 is the vector (read-only). Read data is registered and appears one cycle after the read strobe.

Top module: `ivd_unit`

## Requirements
- R1: `irq_o` is high in the cycle after any of the low MASK_W status bits is set while its mask bit is set, and low otherwise; after reset it is 0.
- R2: A write to select 0 stores only `wr_data[4:0]` as the mask, and a read of select 0 returns that value zero-extended.
- R3: A read strobe to select 3 returns on `rd_data` in the next cycle the 1-based position of the lowest set bit of (status AND mask), or 0 if there is none. In the strobe cycle, `clr_o` carries a one-hot pulse at that bit position, or is all zero if there is none.
- R4: `clr_o` is all zero in every cycle that has no read strobe to select 3, including reads of selects 0, 1 and 2.
- R5: A write to select 1 keeps only bit 15 (receive DMA enable) and bit 7 (transmit DMA enable); a read of select 1 returns exactly those bits.
- R6: A write to select 1 with bit 15 set clears mask bit 3 (receive ready), and one with bit 7 set clears mask bit 4 (transmit ready). Every other mask bit is unchanged.
- R7: While receive DMA is enabled, `dma_rx_req_o` equals status bit 3 from the previous cycle. While transmit DMA is enabled, `dma_tx_req_o` equals status bit 4 from the previous cycle.
- R8: A DMA request line is 0 in the cycle after its enable bit was clear.
- R9: A write to select 2 or 3 changes no state and raises `bad_access_o` for exactly the following cycle; writes to selects 0 and 1 leave it low.
- R10: A read of select 2 returns the full `status_i` word sampled in the strobe cycle.
- R11: After reset the mask and the DMA configuration are 0 and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| status_i | input | DATA_W | Status flags from the controller |
| clr_o | output | DATA_W | One-hot status clear pulse from a vector read |
| irq_o | output | 1 | Interrupt request |
| dma_rx_req_o | output | 1 | Receive DMA request |
| dma_tx_req_o | output | 1 | Transmit DMA request |
| bad_access_o | output | 1 | Pulse marking a write to a read-only register |

## Verification
The bench builds the block with its defaults: a 16-bit word, a 5-bit mask, ready flags at bits 3 and 4, and DMA enables at bits 15 and 7. With only five mask bits, it can sweep all 32 mask values against all 32 low-status patterns. That covers every priority outcome of the vector read, every irq combination and every one-hot clear position, while the upper status bits vary underneath. The four DMA enable combinations are crossed with the four states of the two ready flags, and each enable is tested for the mask bit it clears.

// File: rtl/ivd_pkg.sv
package ivd_pkg;
  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_DMA  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_VEC  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/ivd_regs.sv
module ivd_regs #(
  parameter int DATA_W     = 16,
  parameter int MASK_W     = 5,
  parameter int RX_RDY_IDX = 3,
  parameter int TX_RDY_IDX = 4,
  parameter int RX_DMA_BIT = 15,
  parameter int TX_DMA_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [MASK_W-1:0] mask_o,
  output logic              rx_en_o,
  output logic              tx_en_o,
  output logic              bad_o
);
  import ivd_pkg::*;

  logic [MASK_W-1:0] mask_q;
  logic              rx_en_q, tx_en_q, bad_q;
  logic [MASK_W-1:0] dma_kill;

  // mask bits handed over to DMA by a configuration write
  always_comb begin
    dma_kill = '0;
    if (wr_data[RX_DMA_BIT]) dma_kill[RX_RDY_IDX] = 1'b1;
    if (wr_data[TX_DMA_BIT]) dma_kill[TX_RDY_IDX] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      rx_en_q <= 1'b0;
      tx_en_q <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      bad_q <= 1'b0;
      if (wr_en) begin
        unique case (reg_sel_e'(wr_sel))
          SEL_MASK: mask_q <= wr_data[MASK_W-1:0];
          SEL_DMA: begin
            rx_en_q <= wr_data[RX_DMA_BIT];
            tx_en_q <= wr_data[TX_DMA_BIT];
            mask_q  <= mask_q & ~dma_kill;
          end
          SEL_STAT, SEL_VEC: bad_q <= 1'b1;
          default: bad_q <= 1'b0;
        endcase
      end
    end
  end

  assign mask_o  = mask_q;
  assign rx_en_o = rx_en_q;
  assign tx_en_o = tx_en_q;
  assign bad_o   = bad_q;
endmodule

// File: rtl/ivd_prio.sv
module ivd_prio #(
  parameter int W     = 5,
  parameter int VEC_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     pend,
  output logic [W-1:0]     first_o,
  output logic [VEC_W-1:0] index_o
);
  logic [W:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_chain
    assign first_o[i]  = pend[i] & ~seen[i];
    assign seen[i + 1] = seen[i] | pend[i];
  end

  always_comb begin
    index_o = '0;
    for (int i = 0; i < W; i++) begin
      if (first_o[i]) index_o = VEC_W'(i + 1);
    end
  end
endmodule

// File: rtl/ivd_outs.sv
module ivd_outs #(
  parameter int MASK_W     = 5,
  parameter int RX_RDY_IDX = 3,
  parameter int TX_RDY_IDX = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MASK_W-1:0] flags,
  input  logic [MASK_W-1:0] mask,
  input  logic              rx_en,
  input  logic              tx_en,
  output logic              irq_o,
  output logic              rx_req_o,
  output logic              tx_req_o
);
  logic irq_q, rx_q, tx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      rx_q  <= 1'b0;
      tx_q  <= 1'b0;
    end else begin
      irq_q <= |(flags & mask);
      rx_q  <= rx_en & flags[RX_RDY_IDX];
      tx_q  <= tx_en & flags[TX_RDY_IDX];
    end
  end

  assign irq_o    = irq_q;
  assign rx_req_o = rx_q;
  assign tx_req_o = tx_q;
endmodule

// File: rtl/ivd_unit.sv
module ivd_unit #(
  parameter int DATA_W     = 16,
  parameter int MASK_W     = 5,
  parameter int RX_RDY_IDX = 3,
  parameter int TX_RDY_IDX = 4,
  parameter int RX_DMA_BIT = 15,
  parameter int TX_DMA_BIT = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] status_i,
  output logic [DATA_W-1:0] clr_o,
  output logic              irq_o,
  output logic              dma_rx_req_o,
  output logic              dma_tx_req_o,
  output logic              bad_access_o
);
  import ivd_pkg::*;

  localparam int VEC_W = $clog2(MASK_W + 1);
  localparam int PAD_W = DATA_W - MASK_W;

  logic [MASK_W-1:0] mask_w;
  logic              rx_en_w, tx_en_w;
  logic [MASK_W-1:0] flags_w;
  logic [MASK_W-1:0] first_w;
  logic [VEC_W-1:0]  index_w;
  logic              vec_rd;
  logic [DATA_W-1:0] cfg_word;
  logic [DATA_W-1:0] rd_q;

  assign flags_w = status_i[MASK_W-1:0];
  assign vec_rd  = rd_en && (reg_sel_e'(addr) == SEL_VEC);

  ivd_regs #(
    .DATA_W(DATA_W), .MASK_W(MASK_W),
    .RX_RDY_IDX(RX_RDY_IDX), .TX_RDY_IDX(TX_RDY_IDX),
    .RX_DMA_BIT(RX_DMA_BIT), .TX_DMA_BIT(TX_DMA_BIT)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(addr), .wr_data(wr_data),
    .mask_o(mask_w), .rx_en_o(rx_en_w), .tx_en_o(tx_en_w), .bad_o(bad_access_o)
  );

  ivd_prio #(.W(MASK_W), .VEC_W(VEC_W)) u_prio (
    .pend(flags_w & mask_w), .first_o(first_w), .index_o(index_w)
  );

  ivd_outs #(
    .MASK_W(MASK_W), .RX_RDY_IDX(RX_RDY_IDX), .TX_RDY_IDX(TX_RDY_IDX)
  ) u_outs (
    .clk(clk), .rst(rst), .flags(flags_w), .mask(mask_w),
    .rx_en(rx_en_w), .tx_en(tx_en_w),
    .irq_o(irq_o), .rx_req_o(dma_rx_req_o), .tx_req_o(dma_tx_req_o)
  );

  always_comb begin
    cfg_word             = '0;
    cfg_word[RX_DMA_BIT] = rx_en_w;
    cfg_word[TX_DMA_BIT] = tx_en_w;
  end

  // acknowledge exactly the reported event, in the strobe cycle
  assign clr_o = vec_rd ? {{PAD_W{1'b0}}, first_w} : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (rd_en) begin
      unique case (reg_sel_e'(addr))
        SEL_MASK: rd_q <= {{PAD_W{1'b0}}, mask_w};
        SEL_DMA:  rd_q <= cfg_word;
        SEL_STAT: rd_q <= status_i;
        SEL_VEC:  rd_q <= DATA_W'(index_w);
        default:  rd_q <= '0;
      endcase
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/ivd_unit_chk.sv
module ivd_unit_chk #(
  parameter int DATA_W     = 16,
  parameter int MASK_W     = 5,
  parameter int RX_RDY_IDX = 3,
  parameter int TX_RDY_IDX = 4,
  parameter int RX_DMA_BIT = 15,
  parameter int TX_DMA_BIT = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic              wr_en,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] status_i,
  input logic [DATA_W-1:0] clr_o,
  input logic              irq_o,
  input logic              dma_rx_req_o,
  input logic              dma_tx_req_o,
  input logic              bad_access_o,
  input logic [MASK_W-1:0] mask,
  input logic              rx_en,
  input logic              tx_en
);
  p_irq_follows_r1: assert property (@(posedge clk) disable iff (rst)
    irq_o == $past(|(status_i[MASK_W-1:0] & mask)));

  p_mask_store_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd0) |=> mask == $past(wr_data[MASK_W-1:0]));

  p_clr_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr_o));

  p_clr_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && addr == 2'd3) |-> clr_o == '0);

  p_rx_kill_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd1 && wr_data[RX_DMA_BIT]) |=> !mask[RX_RDY_IDX]);

  p_tx_kill_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd1 && wr_data[TX_DMA_BIT]) |=> !mask[TX_RDY_IDX]);

  p_rx_req_r7: assert property (@(posedge clk) disable iff (rst)
    rx_en |=> dma_rx_req_o == $past(status_i[RX_RDY_IDX]));

  p_tx_req_r7: assert property (@(posedge clk) disable iff (rst)
    tx_en |=> dma_tx_req_o == $past(status_i[TX_RDY_IDX]));

  p_rx_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !dma_rx_req_o);

  p_tx_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> !dma_tx_req_o);

  p_bad_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr[1]) |=> bad_access_o);

  p_bad_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr[1]) |=> !bad_access_o);
endmodule

bind ivd_unit ivd_unit_chk #(
  .DATA_W(DATA_W), .MASK_W(MASK_W),
  .RX_RDY_IDX(RX_RDY_IDX), .TX_RDY_IDX(TX_RDY_IDX),
  .RX_DMA_BIT(RX_DMA_BIT), .TX_DMA_BIT(TX_DMA_BIT)
) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .wr_data(wr_data), .status_i(status_i), .clr_o(clr_o), .irq_o(irq_o),
  .dma_rx_req_o(dma_rx_req_o), .dma_tx_req_o(dma_tx_req_o),
  .bad_access_o(bad_access_o), .mask(mask_w), .rx_en(rx_en_w), .tx_en(tx_en_w)
);

// File: tb/sim_ivd_unit.sv
module sim_ivd_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [15:0] status_i = '0;
  logic [15:0] clr_o;
  logic        irq_o, dma_rx_req_o, dma_tx_req_o, bad_access_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ivd_unit u0 (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .status_i(status_i), .clr_o(clr_o),
    .irq_o(irq_o), .dma_rx_req_o(dma_rx_req_o), .dma_tx_req_o(dma_tx_req_o),
    .bad_access_o(bad_access_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // read: returns data and the clear pulse seen in the strobe cycle;
  // the bench plays the controller and drops acknowledged status bits
  task automatic rd(input logic [1:0] a, output logic [15:0] d, output logic [15:0] c);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 c = clr_o;
    @(negedge clk);
    d = rd_data;
    rd_en = 1'b0;
    status_i = status_i & ~c;
  endtask

  function automatic int lowest(input logic [4:0] v);
    for (int i = 0; i < 5; i++) if (v[i]) return i + 1;
    return 0;
  endfunction

  initial begin
    logic [15:0] d, c;
    int exp_i;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    chk("R11 irq", irq_o, 0);
    chk("R11 rxreq", dma_rx_req_o, 0);
    chk("R11 txreq", dma_tx_req_o, 0);
    chk("R11 bad", bad_access_o, 0);
    rd(2'd0, d, c); chk("R11 mask", d, 0);
    rd(2'd1, d, c); chk("R11 dma", d, 0);

    // R2 mask width
    wr(2'd0, 16'hFFFF); chk("R9 no bad on mask write", bad_access_o, 0);
    rd(2'd0, d, c); chk("R2 mask all ones", d, 16'h001F);
    chk("R4 no clr on mask read", c, 0);
    wr(2'd0, 16'hFFE0); rd(2'd0, d, c); chk("R2 upper ignored", d, 0);

    // R1 R3 R4 exhaustive mask x status sweep
    for (int m = 0; m < 32; m++) begin
      wr(2'd0, 16'(m));
      for (int s = 0; s < 32; s++) begin
        status_i = 16'(((s * 37 + m * 11) & 11'h7FF) << 5) | 16'(s);
        @(negedge clk);
        chk("R1 irq", irq_o, ((s & m) != 0) ? 1 : 0);
        chk("R8 rx idle", dma_rx_req_o, 0);
        exp_i = lowest(5'(s & m));
        rd(2'd3, d, c);
        chk("R3 vector", d, exp_i);
        chk("R3 clear", c, (exp_i == 0) ? 0 : (32'd1 << (exp_i - 1)));
      end
    end

    // R10 status read and R4 quiet clear
    status_i = 16'hA5C3;
    rd(2'd2, d, c); chk("R10 status", d, 16'hA5C3); chk("R4 stat read clr", c, 0);
    status_i = 16'h5A3C;
    rd(2'd2, d, c); chk("R10 status2", d, 16'h5A3C);

    // R9 writes to read-only selects
    wr(2'd0, 16'h0006); status_i = 16'h0006;
    wr(2'd2, 16'hFFFF); chk("R9 bad stat", bad_access_o, 1);
    @(negedge clk); chk("R9 bad pulse ends", bad_access_o, 0);
    wr(2'd3, 16'hFFFF); chk("R9 bad vec", bad_access_o, 1);
    rd(2'd0, d, c); chk("R9 mask kept", d, 16'h0006);
    rd(2'd1, d, c); chk("R9 dma kept", d, 0);
    rd(2'd3, d, c); chk("R9 vector kept", d, 2); chk("R3 clr bit1", c, 16'h0002);
    rd(2'd3, d, c); chk("R3 next vector", d, 3);
    rd(2'd3, d, c); chk("R3 empty vector", d, 0); chk("R3 empty clr", c, 0);

    // R5 R6 DMA configuration
    wr(2'd0, 16'h001F); wr(2'd1, 16'hFFFF);
    rd(2'd1, d, c); chk("R5 keep bits", d, 16'h8080);
    rd(2'd0, d, c); chk("R6 both killed", d, 16'h0007);
    wr(2'd0, 16'h001F); wr(2'd1, 16'h8000);
    rd(2'd0, d, c); chk("R6 rx kills bit3", d, 16'h0017);
    rd(2'd1, d, c); chk("R5 rx only", d, 16'h8000);
    wr(2'd0, 16'h001F); wr(2'd1, 16'h0080);
    rd(2'd0, d, c); chk("R6 tx kills bit4", d, 16'h000F);
    wr(2'd0, 16'h001F); wr(2'd1, 16'h7F7F);
    rd(2'd0, d, c); chk("R6 no kill", d, 16'h001F);
    rd(2'd1, d, c); chk("R5 none kept", d, 0);

    // R7 R8 request lines
    for (int e = 0; e < 4; e++) begin
      wr(2'd1, ((e & 1) ? 16'h8000 : 16'h0) | ((e & 2) ? 16'h0080 : 16'h0));
      for (int f = 0; f < 4; f++) begin
        status_i = 16'h4200 | ((f & 1) ? 16'h0008 : 16'h0) | ((f & 2) ? 16'h0010 : 16'h0);
        @(negedge clk);
        chk("R7 R8 rx req", dma_rx_req_o, ((e & 1) && (f & 1)) ? 1 : 0);
        chk("R7 R8 tx req", dma_tx_req_o, ((e & 2) && (f & 2)) ? 1 : 0);
      end
    end

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule